// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block sits between the memory port of one in-order processor and a single shared-memory port. Stores from the processor are taken into a small queue and count as done at once, then go to memory one at a time, oldest first, so every store from this port becomes visible in one total order. A load whose word address matches a queued store is answered from the youngest such entry in the same cycle, with no trip to memory. A load that matches nothing goes to memory ahead of the queued stores. The processor therefore sees its own writes before shared memory does.

Fence requests carry two 2-bit sets, one for earlier accesses and one for later accesses, with bit 0 meaning read and bit 1 meaning write. The queue already drains in order and serves one load at a time. Only a fence that orders earlier writes before later reads has to wait. It is held until the queue is empty. Every access is a whole 32-bit word. Only one transaction is outstanding on the shared port at any time.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `mem_req_valid` and `ld_ready` are 0, and a fence with both sets equal to 2'b11 is acknowledged in its first cycle.
- R2: Accepted stores reach the memory port as write requests (`mem_req_write`=1) in acceptance order, with unchanged address and data. A new write is issued only after the previous transaction's response.
- R3: With DEPTH entries held, `st_ready` is 0. In a cycle where a write response frees the oldest entry, `st_ready` is 1 and the offered store is kept.
- R4: A load whose address matches no queued entry issues a read request (`mem_req_write`=0). It returns `mem_resp_rdata` on `ld_rdata` with `ld_ready` high in the response cycle, even while older stores are still queued.
- R5: A load whose address matches a queued entry is answered in the cycle it is presented, with `ld_ready` high and no read request on the memory port.
- R6: When several queued entries match a load, the data returned is that of the most recently accepted one.
- R7: A missing load waits for a transaction already in flight to finish. At the next free cycle of the port it is issued before any queued write.
- R8: A fence whose earlier-set has bit 1 (write) and whose later-set has bit 0 (read) is acknowledged only once every queued store has received its write response.
- R9: Any other fence is acknowledged in the cycle it is presented, whatever the queue holds. This includes write/write (2'b10, 2'b10), read/read (2'b01, 2'b01) and read/write (2'b01, 2'b10). Stores on either side of a write/write fence still reach memory in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Processor offers a store |
| st_ready | output | 1 | Store accepted at this edge |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Processor presents a load, held until `ld_ready` |
| ld_ready | output | 1 | Load completes this cycle, data on `ld_rdata` |
| ld_addr | input | AW | Load word address |
| ld_rdata | output | DW | Load result |
| fence_valid | input | 1 | Processor presents a fence, held until `fence_ready` |
| fence_ready | output | 1 | Fence acknowledged |
| fence_pred | input | 2 | Earlier-access set, bit 0 read, bit 1 write |
| fence_succ | input | 2 | Later-access set, bit 0 read, bit 1 write |
| mem_req_valid | output | 1 | Request to shared memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | AW | Request word address |
| mem_req_wdata | output | DW | Write data |
| mem_resp_valid | input | 1 | Response for the outstanding request |
| mem_resp_rdata | input | DW | Read data of the response |

## Verification
The embedded properties check several rules on every cycle: the occupancy never exceeds the depth, a pop only happens on a non-empty queue, a forwarded load never produces a read request, a missing load wins the port over a waiting write, a load in flight excludes new requests, and a write-before-read fence is only acknowledged on an empty queue. The scenarios cover what needs a history. They show that the write order at the memory port matches acceptance order, that the youngest of duplicate addresses is the one forwarded, and that a load really overtakes stores already queued. They also show that the store offered to a full queue is taken in the response cycle and not lost, and which fence forms return without delay.

// File: rtl/stq_pkg.sv
// Package: shared constants for the ordered store queue.
// Assumes fence sets are 2-bit vectors, bit 0 = read, bit 1 = write.
package stq_pkg;
    localparam int FSET_RD = 0;
    localparam int FSET_WR = 1;
    localparam int FSET_W  = 2;
endpackage

// File: rtl/stq_buffer.sv
// Module: circular store queue with youngest-match lookup.
// Holds accepted stores oldest-first; the head stays resident until its
// write response pops it, so in-flight data can still be forwarded.
// Assumes DEPTH is a power of two and at least 2.
module stq_buffer #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [AW-1:0]            push_addr,
    input  logic [DW-1:0]            push_data,
    input  logic                     pop,
    input  logic [AW-1:0]            lookup_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data,
    output logic [AW-1:0]            head_addr,
    output logic [DW-1:0]            head_data,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] head_ptr;
    logic [PW-1:0] tail_ptr;

    assign full      = (level == CW'(DEPTH));
    assign empty     = (level == '0);
    assign head_addr = addr_q[head_ptr];
    assign head_data = data_q[head_ptr];

    // Payload write at the tail; storage needs no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[tail_ptr] <= push_addr;
            data_q[tail_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping for push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            level    <= '0;
        end else begin
            if (push) tail_ptr <= tail_ptr + 1'b1;
            if (pop)  head_ptr <= head_ptr + 1'b1;
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Scan oldest to youngest so the last match, the youngest, wins.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CW'(i) < level) && (addr_q[head_ptr + PW'(i)] == lookup_addr)) begin
                hit      = 1'b1;
                hit_data = data_q[head_ptr + PW'(i)];
            end
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    a_r3_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/stq_mem_arb.sv
// Module: shared-memory port sequencer.
// Allows one outstanding transaction; a pending load miss is preferred over
// the queue head whenever the port is free. Assumes a response arrives for
// every accepted request, in order.
module stq_mem_arb #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_want,
    input  logic [AW-1:0] ld_addr,
    input  logic          wr_want,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_resp_valid,
    output logic          rd_issued,
    output logic          rd_done,
    output logic          wr_done
);
    logic busy;
    logic busy_write;
    logic fire;

    assign mem_req_valid = !busy && (ld_want || wr_want);
    assign mem_req_write = !ld_want;
    assign mem_req_addr  = ld_want ? ld_addr : wr_addr;
    assign mem_req_wdata = wr_data;
    assign fire          = mem_req_valid && mem_req_ready;
    assign rd_done       = busy && !busy_write && mem_resp_valid;
    assign wr_done       = busy &&  busy_write && mem_resp_valid;

    // Track the single outstanding transaction and its kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            busy_write <= 1'b0;
        end else if (fire) begin
            busy       <= 1'b1;
            busy_write <= mem_req_write;
        end else if (mem_resp_valid) begin
            busy       <= 1'b0;
        end
    end

    // Remember that the current load has been sent to memory.
    always_ff @(posedge clk) begin
        if (!rst_n)                      rd_issued <= 1'b0;
        else if (fire && !mem_req_write) rd_issued <= 1'b1;
        else if (rd_done)                rd_issued <= 1'b0;
    end

    a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issued |-> !mem_req_valid);
    a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !mem_req_valid);
endmodule

// File: rtl/stq_fence_gate.sv
// Module: fence acknowledge logic.
// Only write-before-read ordering needs waiting: the queue drains in order and
// loads are served one at a time, so every other combination holds already.
module stq_fence_gate (
    input  logic                      fence_valid,
    input  logic [stq_pkg::FSET_W-1:0] fence_pred,
    input  logic [stq_pkg::FSET_W-1:0] fence_succ,
    input  logic                      buf_empty,
    output logic                      fence_ready
);
    logic need_drain;
    logic unused_bits;

    assign need_drain  = fence_pred[stq_pkg::FSET_WR] && fence_succ[stq_pkg::FSET_RD];
    assign fence_ready = fence_valid && (!need_drain || buf_empty);
    assign unused_bits = fence_pred[stq_pkg::FSET_RD] ^ fence_succ[stq_pkg::FSET_WR];
endmodule

// File: rtl/store_fwd_buffer.sv
// Module: top of the ordered store queue with load forwarding.
// Stores retire into the queue, loads forward from it or bypass it to memory,
// fences wait only when write-before-read ordering is requested.
// Assumes an in-order processor: one load or fence in flight at a time.
module store_fwd_buffer #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic [AW-1:0] ld_addr,
    output logic [DW-1:0] ld_rdata,
    input  logic          fence_valid,
    output logic          fence_ready,
    input  logic [1:0]    fence_pred,
    input  logic [1:0]    fence_succ,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_resp_valid,
    input  logic [DW-1:0] mem_resp_rdata
);
    localparam int LW = $clog2(DEPTH) + 1;

    logic          fwd_hit;
    logic [DW-1:0] fwd_data;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    logic          buf_full;
    logic          buf_empty;
    logic [LW-1:0] buf_level;
    logic          rd_issued;
    logic          rd_done;
    logic          wr_done;
    logic          ld_want;
    logic          push;

    assign st_ready = !buf_full || wr_done;
    assign push     = st_valid && st_ready;
    assign ld_want  = ld_valid && !fwd_hit && !rd_issued;
    assign ld_ready = ld_valid && ((fwd_hit && !rd_issued) || rd_done);
    assign ld_rdata = rd_done ? mem_resp_rdata : fwd_data;

    stq_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) queue_i (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(st_addr), .push_data(st_data),
        .pop(wr_done), .lookup_addr(ld_addr),
        .hit(fwd_hit), .hit_data(fwd_data),
        .head_addr(head_addr), .head_data(head_data),
        .full(buf_full), .empty(buf_empty), .level(buf_level)
    );

    stq_mem_arb #(.AW(AW), .DW(DW)) arb_i (
        .clk(clk), .rst_n(rst_n),
        .ld_want(ld_want), .ld_addr(ld_addr),
        .wr_want(!buf_empty), .wr_addr(head_addr), .wr_data(head_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
        .rd_issued(rd_issued), .rd_done(rd_done), .wr_done(wr_done)
    );

    stq_fence_gate fence_i (
        .fence_valid(fence_valid), .fence_pred(fence_pred),
        .fence_succ(fence_succ), .buf_empty(buf_empty),
        .fence_ready(fence_ready)
    );

    a_r5_fwd_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && fwd_hit && !rd_issued) |-> !(mem_req_valid && !mem_req_write));
    a_r7_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !fwd_hit && !rd_issued && mem_req_valid) |-> !mem_req_write);
    a_r8_fence_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_ready && fence_pred[stq_pkg::FSET_WR] && fence_succ[stq_pkg::FSET_RD])
            |-> (buf_level == '0));
endmodule

// File: tb/store_fwd_buffer_tb_top.sv
module store_fwd_buffer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic        ld_valid = 1'b0;
    logic        ld_ready;
    logic [31:0] ld_addr = '0;
    logic [31:0] ld_rdata;
    logic        fence_valid = 1'b0;
    logic        fence_ready;
    logic [1:0]  fence_pred = '0;
    logic [1:0]  fence_succ = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // scoreboard and memory model state
    logic [63:0] exp_q[$];
    logic [31:0] mem_model [logic [31:0]];
    int mem_lat = 2;
    int m_cnt = 0;
    bit m_busy = 0;
    bit m_wr = 0;
    int rd_count = 0;
    int st_accepted = 0;
    int wr_resp_cnt = 0;
    int pend_at_read = 0;

    always #2 clk = ~clk;

    store_fwd_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_rdata(ld_rdata),
        .fence_valid(fence_valid), .fence_ready(fence_ready),
        .fence_pred(fence_pred), .fence_succ(fence_succ),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
        .mem_resp_rdata(mem_resp_rdata)
    );

    function automatic logic [31:0] mem_peek(logic [31:0] a);
        return mem_model.exists(a) ? mem_model[a] : (a ^ 32'hA5A5_0000);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model and write monitor: pops the scoreboard on each write request.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0;
            mem_resp_valid <= 1'b0;
        end else begin
            mem_resp_valid <= 1'b0;
            if (m_busy) begin
                if (m_cnt == 1) begin
                    mem_resp_valid <= 1'b1;
                    m_busy <= 0;
                    if (m_wr) wr_resp_cnt++;
                end
                m_cnt <= m_cnt - 1;
            end
            if (mem_req_valid && mem_req_ready) begin
                if (m_busy) check("R7 overlap", 32'd1, 32'd0);
                m_busy <= 1;
                m_cnt <= mem_lat;
                m_wr <= mem_req_write;
                if (mem_req_write) begin
                    if (exp_q.size() == 0) begin
                        check("R2 unexpected write", mem_req_addr, 32'hFFFF_FFFF);
                    end else begin
                        logic [63:0] e;
                        e = exp_q.pop_front();
                        check("R2 write addr", mem_req_addr, e[63:32]);
                        check("R2 write data", mem_req_wdata, e[31:0]);
                    end
                    mem_model[mem_req_addr] = mem_req_wdata;
                end else begin
                    mem_resp_rdata <= mem_peek(mem_req_addr);
                    rd_count++;
                    pend_at_read = exp_q.size();
                end
            end
        end
    end

    task automatic do_store(logic [31:0] a, logic [31:0] d, output int waits, output bit resp_seen);
        st_valid = 1'b1; st_addr = a; st_data = d;
        #1; waits = 0;
        while (!st_ready) begin @(negedge clk); #1; waits++; end
        resp_seen = mem_resp_valid;
        exp_q.push_back({a, d});
        st_accepted++;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_load(logic [31:0] a, output logic [31:0] got, output logic [31:0] exp,
                           output int waits, output bit hit);
        hit = 0;
        exp = mem_peek(a);
        foreach (exp_q[i]) if (exp_q[i][63:32] == a) begin exp = exp_q[i][31:0]; hit = 1; end
        ld_valid = 1'b1; ld_addr = a;
        #1; waits = 0;
        while (!ld_ready) begin @(negedge clk); #1; waits++; end
        got = ld_rdata;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic do_fence(logic [1:0] p, logic [1:0] s, output int waits, output int resp_at_ack);
        fence_valid = 1'b1; fence_pred = p; fence_succ = s;
        #1; waits = 0;
        while (!fence_ready) begin @(negedge clk); #1; waits++; end
        resp_at_ack = wr_resp_cnt;
        @(negedge clk);
        fence_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        while (exp_q.size() != 0 || wr_resp_cnt != st_accepted || m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w; bit r; bit h; int ra;
        logic [31:0] got, exp;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        check("R1 st_ready", st_ready, 1);
        check("R1 mem_req_valid", mem_req_valid, 0);
        check("R1 ld_ready", ld_ready, 0);
        @(negedge clk);
        do_fence(2'b11, 2'b11, w, ra);
        check("R1 fence wait", w, 0);

        // R2: in-order drain
        mem_lat = 2;
        do_store(32'h10, 32'h111, w, r);
        do_store(32'h14, 32'h222, w, r);
        do_store(32'h18, 32'h333, w, r);
        wait_quiet();
        check("R2 all drained", exp_q.size(), 0);
        check("R2 memory value", mem_peek(32'h14), 32'h222);

        // R5: forward single match
        mem_lat = 8;
        do_store(32'h20, 32'hAAAA, w, r);
        ra = rd_count;
        do_load(32'h20, got, exp, w, h);
        check("R5 fwd data", got, 32'hAAAA);
        check("R5 fwd same cycle", w, 0);
        check("R5 no read", rd_count, ra);

        // R6: youngest of duplicates
        do_store(32'h30, 32'h1, w, r);
        do_store(32'h30, 32'h2, w, r);
        do_store(32'h34, 32'h3, w, r);
        do_load(32'h30, got, exp, w, h);
        check("R6 youngest", got, 32'h2);
        wait_quiet();

        // R4, R7: miss overtakes queued stores after in-flight write
        mem_lat = 6;
        do_store(32'h40, 32'h4, w, r);
        do_store(32'h44, 32'h5, w, r);
        do_store(32'h48, 32'h6, w, r);
        do_load(32'h80, got, exp, w, h);
        check("R4 miss data", got, mem_peek(32'h80));
        check("R7 load ahead of two queued", pend_at_read, 2);
        wait_quiet();

        // R4: miss with empty queue
        mem_lat = 3;
        do_load(32'h200, got, exp, w, h);
        check("R4 idle miss data", got, 32'h200 ^ 32'hA5A5_0000);

        // R8: write-before-read fence waits for empty queue
        mem_lat = 5;
        do_store(32'h50, 32'h7, w, r);
        do_store(32'h54, 32'h8, w, r);
        do_fence(2'b11, 2'b11, w, ra);
        check("R8 fence stalled", (w > 0), 1);
        check("R8 all written", ra, st_accepted);
        do_store(32'h58, 32'h9, w, r);
        do_fence(2'b10, 2'b01, w, ra);
        check("R8 w,r fence written", ra, st_accepted);

        // R9: other fences pass at once; order kept across w,w
        do_store(32'h60, 32'hA, w, r);
        do_fence(2'b10, 2'b10, w, ra);
        check("R9 w,w no wait", w, 0);
        do_store(32'h64, 32'hB, w, r);
        do_fence(2'b01, 2'b01, w, ra);
        check("R9 r,r no wait", w, 0);
        do_fence(2'b01, 2'b10, w, ra);
        check("R9 r,w no wait", w, 0);
        wait_quiet();
        check("R9 order kept", exp_q.size(), 0);

        // R3: full queue, store taken in response cycle
        mem_lat = 20;
        for (int i = 0; i < 8; i++) do_store(32'h100 + 4 * i, 32'h1000 + i, w, r);
        #1;
        check("R3 full not ready", st_ready, 0);
        do_store(32'h180, 32'hBEEF, w, r);
        check("R3 stalled", (w > 0), 1);
        check("R3 accepted on response", r, 1);
        wait_quiet();
        check("R3 ninth store written", mem_peek(32'h180), 32'hBEEF);

        finish_run();
    end
endmodule